// File: doc/BRIEF.md
# Directory Home Agent with Transient States

This block is the home coherence controller of one cache slice. For each line it owns, it keeps a state and a bit-vector of the private caches that may hold a copy. Cores send read, read-for-ownership and upgrade requests on one request channel. The agent answers each one in one of three ways. It can reply at once. It can send invalidations only to the caches its directory marks. It can send a downgrade to the current writer. In the last two cases it collects the acknowledgements or the returned data before it grants permission.

A line that has just been given write permission stays in a transient state until the new owner confirms the grant. A line that is waiting for acknowledgements or downgrade data is also transient. A parameter picks the policy for requests that meet a transient line. In NACK mode the request is accepted and answered with a retry. In stall mode the request is held off through `req_ready`. A single engine handles invalidation and downgrade collection. Grant confirmations arrive on their own channel and can overlap new traffic to other lines.

Response kinds on `rsp_kind`:
- 0: shared data
- 1: early data without permission
- 2: grant without data
- 3: grant with data
- 4: retry

Request opcodes on `req_op`:
- 1: read-for-ownership
- 2: upgrade
- any other value: read

Top module: `dir_home_agent`

## Requirements
- R1: After reset every line is Invalid and its home data is zero. `req_ready` is 1 and no output valid is asserted.
- R2: A read to an Invalid or Shared line gives kind 0 in the cycle after acceptance, carrying the home data. The requester is then recorded as a sharer.
- R3: A read-for-ownership to a Shared line with other possible holders sends, in the next cycle, one invalidation. Its `inv_mask` holds exactly the recorded sharers other than the requester. In the same cycle the requester receives kind 1 with the home data.
- R4: The acknowledgement count is loaded with the population count of the invalidated set. An `ack_vec` bit only counts for a core that is still pending, and bits for other cores are ignored. Kind 2 reaches the requester only after every pending core has acknowledged.
- R5: A read-for-ownership to a line with no other holder gives kind 3 with the home data in the next cycle, with no invalidation.
- R6: An upgrade from a recorded sharer sends no data. If other sharers exist they are invalidated and kind 2 follows their acknowledgements. If the upgrader is the only sharer, kind 2 arrives in the next cycle.
- R7: After a grant the line stays transient until `gack_valid` names it. It then becomes Modified, with the grantee as sole holder.
- R8: With NACK_MODE=1, a request to a transient line is accepted and answered with kind 4 in the next cycle. The line state is not changed.
- R9: With NACK_MODE=0, `req_ready` is 0 while the requested line is transient. The request is accepted once the line becomes stable.
- R10: A read to a line Modified by another core sends a downgrade to that owner in the next cycle. The owner's `wb_data` is written to the home copy and sent to the requester as kind 0. Afterwards both cores are recorded as sharers.
- R11: A read-for-ownership to a line Modified by another core invalidates only that owner. When the owner returns `wb_data`, the requester receives it as kind 3.
- R12: A read or ownership request from the core that already holds the line Modified is answered with kind 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_core | input | CW | Requesting core |
| req_line | input | LW | Target line |
| req_op | input | 2 | Opcode (1 ownership, 2 upgrade, else read) |
| ack_vec | input | NCORES | Invalidation acknowledgements, one bit per core |
| gack_valid | input | 1 | Grant confirmation present |
| gack_line | input | LW | Line whose grant is confirmed |
| wb_valid | input | 1 | Owner data return present |
| wb_core | input | CW | Core returning the data |
| wb_data | input | DATA_W | Returned line data |
| inv_valid | output | 1 | Invalidation message valid |
| inv_mask | output | NCORES | Cores to invalidate |
| inv_line | output | LW | Line to invalidate |
| dg_valid | output | 1 | Downgrade message valid |
| dg_core | output | CW | Owner to downgrade |
| dg_line | output | LW | Line to downgrade |
| rsp_valid | output | 1 | Response valid |
| rsp_core | output | CW | Core receiving the response |
| rsp_kind | output | 3 | Response kind (0 to 4) |
| rsp_line | output | LW | Line of the response |
| rsp_data | output | DATA_W | Line data |

## Verification
The bench builds two copies, each with 8 cores, 4 lines and 16-bit data. One uses NACK_MODE=1 and the other NACK_MODE=0. This makes it possible to walk every line through every state, using sharer sets derived from the line index. It also makes exact invalidation masks, partial and stray acknowledgements, retries, owner re-requests and the stall hand-off against a grant confirmation all reachable within a few hundred cycles. A reset between rounds shows that both the home data and the directory are cleared.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [2:0] {
        LS_I     = 3'd0,
        LS_S     = 3'd1,
        LS_M     = 3'd2,
        LS_WINV  = 3'd3,
        LS_WGACK = 3'd4,
        LS_WDG   = 3'd5
    } line_st_e;

    typedef enum logic [1:0] {
        EN_IDLE = 2'd0,
        EN_INV  = 2'd1,
        EN_DG   = 2'd2
    } eng_e;

    localparam logic [1:0] OP_OWN = 2'd1;
    localparam logic [1:0] OP_UPG = 2'd2;

    localparam logic [2:0] RK_SHARED = 3'd0;
    localparam logic [2:0] RK_EARLY  = 3'd1;
    localparam logic [2:0] RK_GRANT  = 3'd2;
    localparam logic [2:0] RK_GDATA  = 3'd3;
    localparam logic [2:0] RK_RETRY  = 3'd4;
endpackage

// File: rtl/dir_popcnt.sv
module dir_popcnt #(
    parameter int N = 8,
    localparam int CNTW = $clog2(N + 1)
) (
    input  logic [N-1:0]    vec,
    output logic [CNTW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CNTW'(vec[i]);
        end
    end
endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
    parameter int N = 8,
    localparam int CNTW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [N-1:0]    load_mask,
    input  logic [N-1:0]    ack_vec,
    output logic [N-1:0]    pend,
    output logic [CNTW-1:0] remaining
);
    typedef struct packed {
        logic [N-1:0]    mask;
        logic [CNTW-1:0] cnt;
    } trk_t;

    trk_t q, d;
    logic [N-1:0]    hit;
    logic [CNTW-1:0] load_cnt;
    logic [CNTW-1:0] hit_cnt;

    dir_popcnt #(.N(N)) u_load_cnt (.vec(load_mask), .cnt(load_cnt));
    dir_popcnt #(.N(N)) u_hit_cnt  (.vec(hit),       .cnt(hit_cnt));

    always_comb begin
        d   = q;
        hit = ack_vec & q.mask;
        if (load) begin
            d.mask = load_mask;
            d.cnt  = load_cnt;
        end else begin
            d.mask = q.mask & ~hit;
            d.cnt  = q.cnt - hit_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend      = q.mask;
    assign remaining = q.cnt;

    // R4: the counter always matches the pending set and never underflows
    p_cnt_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        remaining == CNTW'($countones(pend)));
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && remaining == '0) |=> remaining == '0);
endmodule

// File: rtl/dir_home_agent.sv
module dir_home_agent
    import dir_pkg::*;
#(
    parameter int NCORES    = 8,
    parameter int NLINES    = 4,
    parameter int DATA_W    = 16,
    parameter bit NACK_MODE = 1'b1,
    localparam int CW   = $clog2(NCORES),
    localparam int LW   = $clog2(NLINES),
    localparam int CNTW = $clog2(NCORES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CW-1:0]     req_core,
    input  logic [LW-1:0]     req_line,
    input  logic [1:0]        req_op,
    input  logic [NCORES-1:0] ack_vec,
    input  logic              gack_valid,
    input  logic [LW-1:0]     gack_line,
    input  logic              wb_valid,
    input  logic [CW-1:0]     wb_core,
    input  logic [DATA_W-1:0] wb_data,
    output logic              inv_valid,
    output logic [NCORES-1:0] inv_mask,
    output logic [LW-1:0]     inv_line,
    output logic              dg_valid,
    output logic [CW-1:0]     dg_core,
    output logic [LW-1:0]     dg_line,
    output logic              rsp_valid,
    output logic [CW-1:0]     rsp_core,
    output logic [2:0]        rsp_kind,
    output logic [LW-1:0]     rsp_line,
    output logic [DATA_W-1:0] rsp_data
);
    localparam logic [NCORES-1:0] ONE = NCORES'(1);

    typedef struct packed {
        logic [NLINES-1:0][2:0]        lst;
        logic [NLINES-1:0][NCORES-1:0] shr;
        logic [NLINES-1:0][DATA_W-1:0] mem;
        logic [1:0]                    eng;
        logic [CW-1:0]                 t_core;
        logic [LW-1:0]                 t_line;
        logic [CW-1:0]                 t_owner;
        logic                          t_own;
        logic                          rsp_v;
        logic [CW-1:0]                 rsp_core;
        logic [2:0]                    rsp_kind;
        logic [LW-1:0]                 rsp_line;
        logic [DATA_W-1:0]             rsp_data;
        logic                          inv_v;
        logic [NCORES-1:0]             inv_mask;
        logic [LW-1:0]                 inv_line;
        logic                          dg_v;
        logic [CW-1:0]                 dg_core;
        logic [LW-1:0]                 dg_line;
    } st_t;

    st_t q, d;

    logic              trk_load;
    logic [NCORES-1:0] trk_mask;
    logic [NCORES-1:0] trk_pend;
    logic [CNTW-1:0]   trk_rem;

    logic [2:0]        cur;
    logic [NCORES-1:0] req_bit;
    logic [NCORES-1:0] line_shr;
    logic [NCORES-1:0] others;
    logic [CW-1:0]     owner;
    logic              busy_line;
    logic              accept;
    logic              is_own;
    logic              held;

    dir_ack_tracker #(.N(NCORES)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_mask (trk_mask),
        .ack_vec   (ack_vec),
        .pend      (trk_pend),
        .remaining (trk_rem)
    );

    always_comb begin
        d          = q;
        d.rsp_v    = 1'b0;
        d.inv_v    = 1'b0;
        d.dg_v     = 1'b0;
        trk_load   = 1'b0;
        trk_mask   = '0;

        cur       = q.lst[req_line];
        req_bit   = ONE << req_core;
        line_shr  = q.shr[req_line];
        others    = line_shr & ~req_bit;
        owner     = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (line_shr[i]) owner = CW'(i);
        end
        busy_line = (cur == LS_WINV) || (cur == LS_WGACK) || (cur == LS_WDG);
        req_ready = (q.eng == EN_IDLE) && (NACK_MODE || !busy_line);
        accept    = req_valid && req_ready;
        is_own    = (req_op == OP_OWN) || (req_op == OP_UPG);
        held      = (cur == LS_S) && line_shr[req_core];

        // grant confirmation: transient line becomes Modified
        if (gack_valid && q.lst[gack_line] == LS_WGACK) begin
            d.lst[gack_line] = LS_M;
        end

        case (q.eng)
            EN_INV: begin
                if (trk_rem == '0) begin
                    d.rsp_v           = 1'b1;
                    d.rsp_core        = q.t_core;
                    d.rsp_kind        = RK_GRANT;
                    d.rsp_line        = q.t_line;
                    d.shr[q.t_line]   = ONE << q.t_core;
                    d.lst[q.t_line]   = LS_WGACK;
                    d.eng             = EN_IDLE;
                end
            end
            EN_DG: begin
                if (wb_valid && wb_core == q.t_owner) begin
                    d.mem[q.t_line] = wb_data;
                    d.rsp_v         = 1'b1;
                    d.rsp_core      = q.t_core;
                    d.rsp_line      = q.t_line;
                    d.rsp_data      = wb_data;
                    d.eng           = EN_IDLE;
                    if (q.t_own) begin
                        d.rsp_kind      = RK_GDATA;
                        d.shr[q.t_line] = ONE << q.t_core;
                        d.lst[q.t_line] = LS_WGACK;
                    end else begin
                        d.rsp_kind      = RK_SHARED;
                        d.shr[q.t_line] = (ONE << q.t_core) | (ONE << q.t_owner);
                        d.lst[q.t_line] = LS_S;
                    end
                end
            end
            default: begin
                if (accept) begin
                    d.rsp_core = req_core;
                    d.rsp_line = req_line;
                    d.rsp_data = q.mem[req_line];
                    d.t_core   = req_core;
                    d.t_line   = req_line;
                    d.t_owner  = owner;
                    d.t_own    = is_own;
                    if (busy_line || (cur == LS_M && owner == req_core)) begin
                        d.rsp_v    = 1'b1;
                        d.rsp_kind = RK_RETRY;
                    end else if (cur == LS_M) begin
                        d.lst[req_line] = LS_WDG;
                        d.eng           = EN_DG;
                        if (is_own) begin
                            d.inv_v    = 1'b1;
                            d.inv_mask = line_shr;
                            d.inv_line = req_line;
                        end else begin
                            d.dg_v    = 1'b1;
                            d.dg_core = owner;
                            d.dg_line = req_line;
                        end
                    end else if (!is_own) begin
                        d.rsp_v         = 1'b1;
                        d.rsp_kind      = RK_SHARED;
                        d.shr[req_line] = line_shr | req_bit;
                        d.lst[req_line] = LS_S;
                    end else if (others == '0) begin
                        d.rsp_v         = 1'b1;
                        d.rsp_kind      = (req_op == OP_UPG && held) ? RK_GRANT : RK_GDATA;
                        d.shr[req_line] = req_bit;
                        d.lst[req_line] = LS_WGACK;
                    end else begin
                        d.inv_v         = 1'b1;
                        d.inv_mask      = others;
                        d.inv_line      = req_line;
                        d.rsp_v         = !(req_op == OP_UPG && held);
                        d.rsp_kind      = RK_EARLY;
                        trk_load        = 1'b1;
                        trk_mask        = others;
                        d.lst[req_line] = LS_WINV;
                        d.eng           = EN_INV;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign inv_valid = q.inv_v;
    assign inv_mask  = q.inv_mask;
    assign inv_line  = q.inv_line;
    assign dg_valid  = q.dg_v;
    assign dg_core   = q.dg_core;
    assign dg_line   = q.dg_line;
    assign rsp_valid = q.rsp_v;
    assign rsp_core  = q.rsp_core;
    assign rsp_kind  = q.rsp_kind;
    assign rsp_line  = q.rsp_line;
    assign rsp_data  = q.rsp_data;

    // R8: a request that meets a transient line is retried in the next cycle
    p_nack_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (NACK_MODE && accept && busy_line) |=> (rsp_valid && rsp_kind == RK_RETRY));
    // R3: an invalidation never targets the core being served
    p_inv_skips_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_mask & (ONE << q.t_core)) == '0));
    // R4: a grant out of the collection phase only once nothing is pending
    p_grant_after_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.eng == EN_INV) |=> (!(rsp_valid && rsp_kind == RK_GRANT) || $past(trk_pend) == '0));
    // R10: a matching data return always produces a response
    p_wb_responds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.eng == EN_DG && wb_valid && wb_core == q.t_owner) |=> rsp_valid);
    // R1: no messages at all in the first cycle out of reset
    p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_valid && !inv_valid && !dg_valid));
endmodule

// File: tb/sim_dir_home_agent.sv
module sim_dir_home_agent;
    localparam int CLK_P  = 10;
    localparam int NC     = 8;
    localparam int NL     = 4;
    localparam int DW     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic          req_valid = 0, req_ready;
    logic [2:0]    req_core = 0;
    logic [1:0]    req_line = 0;
    logic [1:0]    req_op = 0;
    logic [NC-1:0] ack_vec = 0;
    logic          gack_valid = 0;
    logic [1:0]    gack_line = 0;
    logic          wb_valid = 0;
    logic [2:0]    wb_core = 0;
    logic [DW-1:0] wb_data = 0;
    logic          inv_valid, dg_valid, rsp_valid;
    logic [NC-1:0] inv_mask;
    logic [1:0]    inv_line, dg_line, rsp_line;
    logic [2:0]    dg_core, rsp_core, rsp_kind;
    logic [DW-1:0] rsp_data;

    dir_home_agent #(.NCORES(NC), .NLINES(NL), .DATA_W(DW), .NACK_MODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_core(req_core), .req_line(req_line), .req_op(req_op), .ack_vec(ack_vec),
        .gack_valid(gack_valid), .gack_line(gack_line), .wb_valid(wb_valid),
        .wb_core(wb_core), .wb_data(wb_data), .inv_valid(inv_valid), .inv_mask(inv_mask),
        .inv_line(inv_line), .dg_valid(dg_valid), .dg_core(dg_core), .dg_line(dg_line),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_kind(rsp_kind),
        .rsp_line(rsp_line), .rsp_data(rsp_data));

    logic          s_req_valid = 0, s_req_ready;
    logic [2:0]    s_req_core = 0;
    logic [1:0]    s_req_line = 0;
    logic [1:0]    s_req_op = 0;
    logic          s_gack_valid = 0;
    logic [1:0]    s_gack_line = 0;
    logic          s_inv_valid, s_dg_valid, s_rsp_valid;
    logic [NC-1:0] s_inv_mask;
    logic [1:0]    s_inv_line, s_dg_line, s_rsp_line;
    logic [2:0]    s_dg_core, s_rsp_core, s_rsp_kind;
    logic [DW-1:0] s_rsp_data;

    dir_home_agent #(.NCORES(NC), .NLINES(NL), .DATA_W(DW), .NACK_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_ready(s_req_ready),
        .req_core(s_req_core), .req_line(s_req_line), .req_op(s_req_op), .ack_vec('0),
        .gack_valid(s_gack_valid), .gack_line(s_gack_line), .wb_valid(1'b0),
        .wb_core(3'd0), .wb_data('0), .inv_valid(s_inv_valid), .inv_mask(s_inv_mask),
        .inv_line(s_inv_line), .dg_valid(s_dg_valid), .dg_core(s_dg_core),
        .dg_line(s_dg_line), .rsp_valid(s_rsp_valid), .rsp_core(s_rsp_core),
        .rsp_kind(s_rsp_kind), .rsp_line(s_rsp_line), .rsp_data(s_rsp_data));

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive a request at a negedge; return at the negedge after acceptance
    task automatic send(input int core, input int line, input int op, input string rq);
        chk(req_ready === 1'b1, rq, req_ready, 1);
        req_valid = 1'b1; req_core = 3'(core); req_line = 2'(line); req_op = 2'(op);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_rsp(input int core, input int kind, input int data, input string rq);
        chk(rsp_valid === 1'b1, rq, rsp_valid, 1);
        chk(rsp_core == 3'(core) && rsp_kind == 3'(kind), rq,
            {rsp_core, rsp_kind}, {core[2:0], kind[2:0]});
        chk(rsp_data == DW'(data), rq, rsp_data, data);
    endtask

    task automatic ack(input logic [NC-1:0] m);
        ack_vec = m;
        @(negedge clk);
        ack_vec = '0;
    endtask

    task automatic gack(input int line);
        gack_valid = 1'b1; gack_line = 2'(line);
        @(negedge clk);
        gack_valid = 1'b0;
    endtask

    task automatic wb(input int core, input int data);
        wb_valid = 1'b1; wb_core = 3'(core); wb_data = DW'(data);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        for (int k = 0; k < 6; k++) begin
            if (rsp_valid) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [NC-1:0] b(input int c);
        return NC'(1) << (c % NC);
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(req_ready === 1'b1 && s_req_ready === 1'b1, "R1 ready", req_ready, 1);
        chk(!rsp_valid && !inv_valid && !dg_valid, "R1 quiet", {rsp_valid, inv_valid, dg_valid}, 0);

        // Round 1: full life of every line
        for (int L = 0; L < NL; L++) begin
            int a0 = L, a1 = (L + 2) % NC, a2 = (L + 5) % NC;
            int x = (L + 1) % NC, y = (L + 3) % NC, z = (L + 4) % NC, w = (L + 6) % NC;
            int st = (L + 7) % NC;
            int d1 = 16'hA000 + L, d2 = 16'hB000 + L;
            send(a0, L, 0, "R2"); chk_rsp(a0, 0, 0, "R2 read I");
            send(a1, L, 0, "R2"); chk_rsp(a1, 0, 0, "R2 read S");
            send(a2, L, 3, "R2"); chk_rsp(a2, 0, 0, "R2 read op3");
            send(x, L, 1, "R3");
            chk(inv_valid && inv_line == 2'(L), "R3 inv", inv_valid, 1);
            chk(inv_mask == (b(a0) | b(a1) | b(a2)), "R3 mask", inv_mask, b(a0) | b(a1) | b(a2));
            chk_rsp(x, 1, 0, "R3 early data");
            ack(b(a0) | b(st));
            chk(!rsp_valid, "R4 partial", rsp_valid, 0);
            @(negedge clk);
            chk(!rsp_valid, "R4 stray ignored", rsp_valid, 0);
            ack(b(a1) | b(a2));
            wait_rsp();
            chk_rsp(x, 2, 0, "R4 grant");
            send(y, L, 0, "R8");
            chk_rsp(y, 4, 0, "R8 nack");
            chk(!dg_valid, "R8 no downgrade", dg_valid, 0);
            gack(L);
            send(y, L, 0, "R10");
            chk(dg_valid && dg_core == 3'(x) && dg_line == 2'(L), "R10 dg", dg_core, x);
            chk(!rsp_valid, "R10 wait", rsp_valid, 0);
            wb(x, d1);
            chk_rsp(y, 0, d1, "R10 data");
            send(z, L, 1, "R10");
            chk(inv_valid && inv_mask == (b(x) | b(y)), "R10 sharers", inv_mask, b(x) | b(y));
            chk_rsp(z, 1, d1, "R10 home copy");
            ack(b(x) | b(y));
            wait_rsp();
            chk_rsp(z, 2, d1, "R4 grant 2");
            gack(L);
            send(z, L, 0, "R12");
            chk_rsp(z, 4, d1, "R12 owner retry");
            send(w, L, 1, "R11");
            chk(inv_valid && inv_mask == b(z), "R11 inv owner", inv_mask, b(z));
            chk(!rsp_valid && !dg_valid, "R11 wait", rsp_valid, 0);
            wb(z, d2);
            chk_rsp(w, 3, d2, "R11 grant data");
            gack(L);
            send(y, L, 1, "R7");
            chk(inv_valid && inv_mask == b(w), "R7 sole owner", inv_mask, b(w));
            wb(w, d2);
            chk_rsp(y, 3, d2, "R7 handover");
            gack(L);
        end

        // Round 2: upgrade with other sharers, and reset clears home data
        do_reset();
        for (int L = 0; L < NL; L++) begin
            int a0 = L, a1 = (L + 2) % NC;
            send(a0, L, 0, "R1"); chk_rsp(a0, 0, 0, "R1 data cleared");
            send(a1, L, 0, "R2"); chk_rsp(a1, 0, 0, "R2 second");
            send(a0, L, 2, "R6");
            chk(inv_valid && inv_mask == b(a1), "R6 inv others", inv_mask, b(a1));
            chk(!rsp_valid, "R6 no data", rsp_valid, 0);
            ack(b(a1));
            wait_rsp();
            chk_rsp(a0, 2, 0, "R6 grant");
            gack(L);
        end

        // Round 3: sole-sharer upgrade and ownership from Invalid
        do_reset();
        for (int L = 0; L < NL; L++) begin
            if (L % 2 == 0) begin
                send(L, L, 0, "R6"); chk_rsp(L, 0, 0, "R6 read");
                send(L, L, 2, "R6");
                chk_rsp(L, 2, 0, "R6 sole grant");
                chk(!inv_valid, "R6 no inv", inv_valid, 0);
            end else begin
                send(L, L, 1, "R5");
                chk_rsp(L, 3, 0, "R5 grant data");
                chk(!inv_valid, "R5 no inv", inv_valid, 0);
            end
            gack(L);
            send((L + 1) % NC, L, 0, "R7");
            chk(dg_valid && dg_core == 3'(L), "R7 modified", dg_core, L);
            wb(L, 16'h5000 + L);
            chk_rsp((L + 1) % NC, 0, 16'h5000 + L, "R7 dg data");
        end

        // Stall mode on u1 (R9)
        s_req_valid = 1'b1; s_req_core = 3'd1; s_req_line = 2'd0; s_req_op = 2'd1;
        @(negedge clk);
        s_req_valid = 1'b0;
        chk(s_rsp_valid && s_rsp_kind == 3'd3, "R9 setup grant", s_rsp_kind, 3);
        s_req_valid = 1'b1; s_req_core = 3'd2; s_req_line = 2'd0; s_req_op = 2'd0;
        #1;
        chk(s_req_ready === 1'b0, "R9 stall", s_req_ready, 0);
        @(negedge clk);
        chk(s_req_ready === 1'b0 && !s_rsp_valid, "R9 held", s_req_ready, 0);
        s_req_line = 2'd1;
        #1;
        chk(s_req_ready === 1'b1, "R9 other line ready", s_req_ready, 1);
        s_req_line = 2'd0;
        s_gack_valid = 1'b1; s_gack_line = 2'd0;
        @(negedge clk);
        s_gack_valid = 1'b0;
        chk(s_req_ready === 1'b1, "R9 released", s_req_ready, 1);
        @(negedge clk);
        s_req_valid = 1'b0;
        chk(s_dg_valid && s_dg_core == 3'd1, "R9 accepted", s_dg_core, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule